// File: doc/BRIEF.md
# Tearing-Effect Sync Pulse Detector

A display panel reports its refresh position on one tearing-effect pin, and that single wire carries two kinds of pulse: short ones once per scanned line and a long one once per frame. This block brings the pin into the local clock domain and measures how long the line stays at each level. The time base is a divided tick, with a divide ratio from 1 to 8. At the end of every run it decides from the measured width whether the run was a horizontal pulse, a vertical pulse or noise. The active level of the horizontal pulse and of the vertical pulse can each be inverted on its own.

The block counts horizontal pulses after each vertical pulse to find the current line. When the programmed trigger condition is met, it drops its match output for one clock cycle, and a downstream interrupt consumer that triggers on that falling edge releases a pending frame transfer. Two trigger modes exist. One fires on every vertical pulse. The other fires on every vertical pulse and also on the horizontal pulse of a chosen line. The remaining mode codes never fire. A global enable bypasses the whole block: while it is low, all state is held cleared and the output stays idle.

Top module: `te_sync_detect`

## Requirements
- R1: After reset, `te_match` is high (inactive) and `vsync_seen` is low.
- R2: Run widths are counted in ticks of the clock divided by `clk_div`+1, so `clk_div` 0..7 gives a divide of 1..8. The pin passes through a two-flop synchronizer before it is measured.
- R3: A run at the vertical active level lasting at least `vs_min_ticks` ticks is a vertical pulse. A vertical pulse sets `vsync_seen` and restarts the line count at 0.
- R4: A run at the horizontal active level lasting at least `hs_min_ticks` ticks, and not classed vertical, is a horizontal pulse that advances the line count by one. Shorter runs are ignored and do not advance the count.
- R5: The vertical active level is high when `vs_invert`=0 and low when `vs_invert`=1. The horizontal active level is set by `hs_invert` in the same way, independently of `vs_invert`.
- R6: With `sync_mode`=3, every vertical pulse produces a match and horizontal pulses produce none.
- R7: With `sync_mode`=2, every vertical pulse produces a match. A horizontal pulse also produces a match when its line index equals `target_line`, where the first horizontal pulse after a vertical pulse has index 0.
- R8: With `sync_mode`=0 or 1, no match is produced, while `vsync_seen` still follows vertical pulses.
- R9: While `sync_en` is low, `te_match` stays high, `vsync_seen` is low, and pulses on the pin are neither classified nor counted.
- R10: A match drives `te_match` low for exactly one clock cycle. The edge that ends the triggering run reaches `te_match` four clock edges after the pin changes.
- R11: Width measurement saturates at 4095 ticks, so a run far longer than that, with `vs_min_ticks`=4095, is still a vertical pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_en | input | 1 | Enables the detector; low bypasses and clears it |
| sync_mode | input | 2 | 0/1 never match, 2 line-or-vertical, 3 vertical only |
| clk_div | input | 3 | Tick divide minus one (0..7 = divide 1..8) |
| hs_min_ticks | input | 12 | Minimum width of a horizontal pulse in ticks |
| vs_min_ticks | input | 12 | Minimum width of a vertical pulse in ticks (8..4095, above hs_min_ticks) |
| hs_invert | input | 1 | Horizontal pulses are active low when set |
| vs_invert | input | 1 | Vertical pulses are active low when set |
| target_line | input | 11 | Line index that triggers a match in mode 2 |
| te_pin | input | 1 | Tearing-effect pin from the panel, asynchronous |
| te_match | output | 1 | Active-low one-cycle match pulse |
| vsync_seen | output | 1 | Set once a vertical pulse has been seen since enable |

## Verification
The bench puts a short glitch just before the target line. A design that counted every edge instead of every qualified run would fire one line early. It sends a pulse that is vertical at divide 1 but horizontal at divide 4, so a divider that is off by one or ignored fires a match where none belongs. It also runs mixed polarities, where the gaps between horizontal pulses sit at the vertical level: a design that tied the two polarity controls together would misclassify those gaps or miss the frame pulse. Further cases cover a 5000-cycle frame pulse against the largest threshold, which catches a wrapping width counter, and pulses sent while disabled or in an idle mode, which must leave the output quiet.

// File: rtl/te_sync_pkg.sv
package te_sync_pkg;

   typedef enum logic [1:0] {
      MODE_OFF        = 2'd0,
      MODE_RESERVED   = 2'd1,
      MODE_LINE_OR_VS = 2'd2,
      MODE_VS_ONLY    = 2'd3
   } te_mode_e;

   typedef enum logic [1:0] {
      PULSE_NONE = 2'd0,
      PULSE_HS   = 2'd1,
      PULSE_VS   = 2'd2
   } pulse_kind_e;

endpackage

// File: rtl/te_sync_input.sv
module te_sync_input #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic pin,
   output logic run_lvl,
   output logic edge_o
);

   logic [STAGES-1:0] chain;
   logic              synced;
   logic              lvl_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= pin;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= 1'b0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign synced = chain[STAGES-1];

   // level of the run currently being measured
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lvl_q <= 1'b0;
      else if (!en) lvl_q <= 1'b0;
      else          lvl_q <= synced;
   end

   assign edge_o  = en && (synced != lvl_q);
   assign run_lvl = lvl_q;

   AST_EDGE_FLIPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> (run_lvl == !$past(run_lvl)));  // R2

endmodule

// File: rtl/te_width_meter.sv
module te_width_meter
   import te_sync_pkg::*;
#(
   parameter int WIDTH_W = 12,
   parameter int DIV_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [DIV_W-1:0]   cfg_div,
   input  logic [WIDTH_W-1:0] hs_thr,
   input  logic [WIDTH_W-1:0] vs_thr,
   input  logic               hs_inv,
   input  logic               vs_inv,
   input  logic               run_lvl,
   input  logic               edge_i,
   output logic               hs_evt,
   output logic               vs_evt
);

   localparam logic [WIDTH_W-1:0] RUN_MAX = {WIDTH_W{1'b1}};

   logic [DIV_W-1:0]   pre_cnt;
   logic               tick;
   logic [WIDTH_W-1:0] run_cnt;
   pulse_kind_e        kind;
   logic               vs_hit;
   logic               hs_hit;

   // tick prescaler: one tick every cfg_div+1 clocks
   assign tick = (pre_cnt == cfg_div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pre_cnt <= '0;
      else if (!en)  pre_cnt <= '0;
      else if (tick) pre_cnt <= '0;
      else           pre_cnt <= pre_cnt + 1'b1;
   end

   // saturating run-width counter, restarted at every level change
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        run_cnt <= '0;
      else if (!en || edge_i)            run_cnt <= '0;
      else if (tick && run_cnt != RUN_MAX) run_cnt <= run_cnt + 1'b1;
   end

   // classification of the run that just ended
   always_comb begin
      vs_hit = (run_lvl == !vs_inv) && (run_cnt >= vs_thr);
      hs_hit = (run_lvl == !hs_inv) && (run_cnt >= hs_thr);
      if (vs_hit)      kind = PULSE_VS;
      else if (hs_hit) kind = PULSE_HS;
      else             kind = PULSE_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_evt <= 1'b0;
         vs_evt <= 1'b0;
      end else begin
         hs_evt <= edge_i && (kind == PULSE_HS);
         vs_evt <= edge_i && (kind == PULSE_VS);
      end
   end

   AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_evt && vs_evt));  // R4
   AST_EVT_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_evt || vs_evt) |-> $past(edge_i));  // R3
   AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !edge_i && run_cnt == RUN_MAX) |=> (run_cnt == RUN_MAX));  // R11

endmodule

// File: rtl/te_line_matcher.sv
module te_line_matcher
   import te_sync_pkg::*;
#(
   parameter int LINE_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [1:0]        mode,
   input  logic [LINE_W-1:0] cfg_line,
   input  logic              hs_evt,
   input  logic              vs_evt,
   output logic              match_q,
   output logic              vs_seen
);

   localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

   te_mode_e          mode_e;
   logic [LINE_W-1:0] line_cnt;
   logic              line_hit;
   logic              fire;

   assign mode_e   = te_mode_e'(mode);
   assign line_hit = hs_evt && (line_cnt == cfg_line);

   always_comb begin
      unique case (mode_e)
         MODE_VS_ONLY:    fire = vs_evt;
         MODE_LINE_OR_VS: fire = vs_evt || line_hit;
         default:         fire = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_cnt <= '0;
         match_q  <= 1'b0;
         vs_seen  <= 1'b0;
      end else if (!en) begin
         line_cnt <= '0;
         match_q  <= 1'b0;
         vs_seen  <= 1'b0;
      end else begin
         match_q <= fire;
         if (vs_evt) begin
            line_cnt <= '0;
            vs_seen  <= 1'b1;
         end else if (hs_evt && line_cnt != LINE_MAX) begin
            line_cnt <= line_cnt + 1'b1;
         end
      end
   end

   AST_VS_CLEARS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && vs_evt) |=> (line_cnt == '0));  // R3
   AST_NO_MATCH_IDLE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      match_q |-> $past(mode[1]));  // R8

endmodule

// File: rtl/te_sync_detect.sv
module te_sync_detect #(
   parameter int LINE_W           = 11,
   parameter int WIDTH_W          = 12,
   parameter int DIV_W            = 3,
   parameter int SYNC_STAGES      = 2,
   parameter bit MATCH_ACTIVE_LOW = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sync_en,
   input  logic [1:0]         sync_mode,
   input  logic [DIV_W-1:0]   clk_div,
   input  logic [WIDTH_W-1:0] hs_min_ticks,
   input  logic [WIDTH_W-1:0] vs_min_ticks,
   input  logic               hs_invert,
   input  logic               vs_invert,
   input  logic [LINE_W-1:0]  target_line,
   input  logic               te_pin,
   output logic               te_match,
   output logic               vsync_seen
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("te_sync_detect: SYNC_STAGES must be at least 2");
      end
      if (WIDTH_W < 4 || LINE_W < 1 || DIV_W < 1) begin : g_bad_width
         $error("te_sync_detect: WIDTH_W >= 4, LINE_W >= 1, DIV_W >= 1 required");
      end
   endgenerate

   logic run_lvl;
   logic edge_w;
   logic hs_evt;
   logic vs_evt;
   logic match_q;

   te_sync_input #(.STAGES(SYNC_STAGES)) u_input (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (sync_en),
      .pin     (te_pin),
      .run_lvl (run_lvl),
      .edge_o  (edge_w)
   );

   te_width_meter #(.WIDTH_W(WIDTH_W), .DIV_W(DIV_W)) u_meter (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (sync_en),
      .cfg_div (clk_div),
      .hs_thr  (hs_min_ticks),
      .vs_thr  (vs_min_ticks),
      .hs_inv  (hs_invert),
      .vs_inv  (vs_invert),
      .run_lvl (run_lvl),
      .edge_i  (edge_w),
      .hs_evt  (hs_evt),
      .vs_evt  (vs_evt)
   );

   te_line_matcher #(.LINE_W(LINE_W)) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (sync_en),
      .mode     (sync_mode),
      .cfg_line (target_line),
      .hs_evt   (hs_evt),
      .vs_evt   (vs_evt),
      .match_q  (match_q),
      .vs_seen  (vsync_seen)
   );

   generate
      if (MATCH_ACTIVE_LOW) begin : g_out_low
         assign te_match = !match_q;
      end else begin : g_out_high
         assign te_match = match_q;
      end
   endgenerate

   AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_en |=> (!match_q && !vsync_seen));  // R9

endmodule

// File: tb/te_sync_detect_bench.sv
module te_sync_detect_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sync_en = 1'b0;
   logic [1:0]  sync_mode = 2'd0;
   logic [2:0]  clk_div = 3'd0;
   logic [11:0] hs_min_ticks = 12'd10;
   logic [11:0] vs_min_ticks = 12'd100;
   logic        hs_invert = 1'b0;
   logic        vs_invert = 1'b0;
   logic [10:0] target_line = 11'd0;
   logic        te_pin = 1'b0;
   logic        te_match;
   logic        vsync_seen;

   always #10 clk = ~clk;  // 50 MHz

   te_sync_detect u_te_sync_detect (
      .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .sync_mode(sync_mode),
      .clk_div(clk_div), .hs_min_ticks(hs_min_ticks), .vs_min_ticks(vs_min_ticks),
      .hs_invert(hs_invert), .vs_invert(vs_invert), .target_line(target_line),
      .te_pin(te_pin), .te_match(te_match), .vsync_seen(vsync_seen)
   );

   int    checks = 0;
   int    errors = 0;
   int    cur_id = 0;
   bit    done = 0;
   int    exp_id[$];
   string exp_tag[$];
   int    m_line = 0;
   bit    m_en = 0;
   bit    prev_m = 1'b1;

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // reference classification: 0 none, 1 horizontal, 2 vertical
   function automatic int classify(bit lvl, int n);
      int t;
      t = n / (int'(clk_div) + 1);
      if (t > 4095) t = 4095;
      if (lvl == !vs_invert && t >= int'(vs_min_ticks)) return 2;
      if (lvl == !hs_invert && t >= int'(hs_min_ticks)) return 1;
      return 0;
   endfunction

   // driver: one run of n cycles at level lvl; pushes the expected match
   task automatic seg(bit lvl, int n, string tag);
      int  k;
      bit  fire;
      @(posedge clk); #1;
      te_pin = lvl;
      cur_id++;
      if (m_en) begin
         k = classify(lvl, n);
         fire = (k == 2 && sync_mode[1]) ||
                (k == 1 && sync_mode == 2'd2 && m_line == int'(target_line));
         if (k == 2) m_line = 0;
         else if (k == 1 && m_line < 2047) m_line++;
         if (fire) begin
            exp_id.push_back(cur_id + 1);
            exp_tag.push_back(tag);
         end
      end
      repeat (n - 1) @(posedge clk);
   endtask

   task automatic restart(bit idle);
      @(posedge clk); #1;
      sync_en = 1'b0;
      te_pin  = idle;
      repeat (4) @(posedge clk);
      #1;
      sync_en = 1'b1;
      m_en    = 1'b1;
      m_line  = 0;
   endtask

   // monitor: scoreboard compare on each falling edge of te_match
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (!te_match && prev_m) begin
            if (exp_id.size() == 0) begin
               check(0, "R8/R9 unexpected match", cur_id, -1);
            end else begin
               int    id;
               string tg;
               id = exp_id.pop_front();
               tg = exp_tag.pop_front();
               check(id == cur_id, tg, cur_id, id);
            end
         end
         if (!te_match && !prev_m) check(0, "R10 match longer than one cycle", 0, 1);
         prev_m = te_match;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(te_match == 1'b1, "R1 match idle in reset", te_match, 1);
      check(vsync_seen == 1'b0, "R1 status clear in reset", vsync_seen, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(te_match == 1'b1, "R1 match idle after reset", te_match, 1);
      check(vsync_seen == 1'b0, "R1 status clear after reset", vsync_seen, 0);

      // R6: vertical-only mode
      sync_mode = 2'd3;
      restart(1'b0);
      seg(0, 20, "R6");
      seg(1, 30, "R6 hs"); seg(0, 30, "R6"); seg(1, 30, "R6 hs"); seg(0, 30, "R6");
      seg(1, 200, "R6 vertical match"); seg(0, 30, "R6");
      @(negedge clk);
      check(vsync_seen == 1'b1, "R3 status after vertical", vsync_seen, 1);

      // R7 / R4 / R3: line match with glitch, then line restart
      sync_mode = 2'd2; target_line = 11'd2;
      seg(1, 200, "R7 vertical match"); seg(0, 30, "R7");
      seg(1, 30, "R7 line0"); seg(0, 30, "R7");
      seg(1, 30, "R7 line1"); seg(0, 12, "R4");
      seg(1, 4, "R4 glitch"); seg(0, 12, "R4");
      seg(1, 30, "R4 R7 line2 match"); seg(0, 30, "R7");
      seg(1, 30, "R7 line3"); seg(0, 30, "R7");
      seg(1, 200, "R3 vertical match"); seg(0, 30, "R3");
      seg(1, 30, "R3 line0"); seg(0, 30, "R3");
      seg(1, 30, "R3 line1"); seg(0, 30, "R3");
      seg(1, 30, "R3 line2 match after restart"); seg(0, 30, "R3");

      // R2: divide by 4
      sync_mode = 2'd3; clk_div = 3'd3; vs_min_ticks = 12'd50;
      restart(1'b0);
      seg(0, 20, "R2");
      seg(1, 120, "R2 horizontal at divide 4"); seg(0, 40, "R2");
      seg(1, 300, "R2 vertical at divide 4"); seg(0, 40, "R2");

      // R9: disabled
      @(posedge clk); #1;
      sync_en = 1'b0; m_en = 1'b0; clk_div = 3'd0; vs_min_ticks = 12'd100;
      seg(1, 200, "R9"); seg(0, 30, "R9"); seg(1, 30, "R9"); seg(0, 30, "R9");
      @(negedge clk);
      check(vsync_seen == 1'b0, "R9 status cleared while disabled", vsync_seen, 0);
      check(te_match == 1'b1, "R9 match idle while disabled", te_match, 1);

      // R5: both inverted
      hs_invert = 1'b1; vs_invert = 1'b1;
      restart(1'b1);
      seg(1, 20, "R5");
      seg(0, 200, "R5 low vertical match"); seg(1, 30, "R5");
      seg(0, 30, "R5 low horizontal"); seg(1, 30, "R5");

      // R5: mixed polarity, horizontal high, vertical low
      hs_invert = 1'b0; vs_invert = 1'b1; sync_mode = 2'd2; target_line = 11'd1;
      restart(1'b0);
      seg(0, 20, "R5");
      seg(1, 30, "R5 hs before frame"); seg(0, 200, "R5 mixed vertical match");
      seg(1, 30, "R5 line0"); seg(0, 30, "R5 gap");
      seg(1, 30, "R5 mixed line1 match"); seg(0, 30, "R5");

      // R8: idle mode still tracks status
      hs_invert = 1'b0; vs_invert = 1'b0; sync_mode = 2'd0; target_line = 11'd0;
      restart(1'b0);
      seg(0, 20, "R8");
      seg(1, 200, "R8"); seg(0, 30, "R8"); seg(1, 30, "R8"); seg(0, 30, "R8");
      @(negedge clk);
      check(vsync_seen == 1'b1, "R8 status tracks in idle mode", vsync_seen, 1);
      sync_mode = 2'd1;
      seg(1, 200, "R8"); seg(0, 30, "R8");

      // R11: saturation
      sync_mode = 2'd3; vs_min_ticks = 12'd4095;
      restart(1'b0);
      seg(0, 20, "R11");
      seg(1, 5000, "R11 saturated vertical match"); seg(0, 30, "R11");
      seg(1, 30, "R11 hs"); seg(0, 30, "R11");

      repeat (10) @(negedge clk);
      check(exp_id.size() == 0, "R10 all expected matches seen", exp_id.size(), 0);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule